// File: doc/BRIEF.md
# Serial Line Code Encoder

This block turns a serial stream of NRZ data bits into one of four line codes, picked by a 2-bit mode input. The four codes are plain level, transition-on-one (NRZI), return-to-zero and Manchester. The block runs from a clock at twice the bit rate, so every bit time splits into two half-bit clock periods. A half-bit phase flag decides when a new bit is taken in.

A data bit and the mode are captured once, on the clock edge that opens a bit time. Both are then held for the two halves. The line level for each half is written into an output register, so the line only changes right after a clock edge. A change on the inputs between edges can never produce a glitch on the line. For NRZI, a reference register stores the level most recently sent in that mode.

Top module: `line_encoder`

## Requirements
- R1: Synchronous reset drives the line low, clears the NRZI reference level to 0 and puts the phase flag in the first half. The first rising edge after reset is released opens a bit time.
- R2: A bit time lasts two clock periods. Data and mode are sampled on the edge that opens it, and the level for the first half appears on the line right after that edge. Between edges the line does not follow the inputs.
- R3: Mode 2'b00 (plain NRZ) holds the line at the data value for both halves.
- R4: In mode 2'b01 (NRZI), a 0 bit repeats the stored reference level for both halves.
- R5: In mode 2'b01 (NRZI), a 1 bit sends the inverse of the stored reference level for both halves. That new level becomes the reference.
- R6: In mode 2'b10 (RZ), a 0 bit is low for both halves. A 1 bit is high in the first half and low in the second.
- R7: In mode 2'b11 (Manchester), a 0 bit is low then high and a 1 bit is high then low, so every bit has a transition at mid-bit.
- R8: A change of data or mode input during the second half of a bit has no effect on that bit's second-half level.
- R9: Bits sent in modes other than NRZI leave the NRZI reference level unchanged. A later NRZI bit continues from the last NRZI level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | NRZ data bit, sampled at the start of a bit time |
| modeSel | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| lineOut | output | 1 | Encoded line level, registered |

## Verification
The assertions assume that the only event that puts the block back into its first half is a synchronous reset. Apart from that, the phase advances one step per clock, with no stall or skip input. They also assume that the mode only changes inside the block when a bit is loaded. The stimulus therefore changes the data and mode inputs only in the clock low phase, away from the rising edge. Every new bit is presented before the edge that opens a bit time. Mid-bit changes are made only after that edge, to show that they are ignored.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CODE_NRZ  = 2'b00,
    CODE_NRZI = 2'b01,
    CODE_RZ   = 2'b10,
    CODE_MAN  = 2'b11
  } lineCode_e;

  typedef struct packed {
    logic loadBit;     // edge opens a bit: capture inputs, drive first half
    logic secondHalf;  // edge drives the second half from held state
  } encStrobe_t;
endpackage

// File: rtl/line_enc_ctrl.sv
module line_enc_ctrl
  import line_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output logic       phase,
  output encStrobe_t strobe
);
  // phase = 0: next edge opens a new bit; phase = 1: next edge is mid-bit
  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= ~phase;
  end

  always_comb begin
    strobe.loadBit    = ~phase & ~rst;
    strobe.secondHalf =  phase & ~rst;
  end
endmodule

// File: rtl/line_enc_datapath.sv
module line_enc_datapath
  import line_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  encStrobe_t        strobe,
  input  logic              dataIn,
  input  logic [MODE_W-1:0] modeSel,
  output lineCode_e         modeReg,
  output logic              lineOut
);
  logic      bitReg;
  logic      prevLvl;
  logic      firstLvl;
  logic      secondLvl;
  lineCode_e modeIn;

  assign modeIn = lineCode_e'(modeSel);

  always_comb begin
    case (modeIn)
      CODE_NRZI: firstLvl = prevLvl ^ dataIn;
      default:   firstLvl = dataIn;
    endcase
  end

  always_comb begin
    case (modeReg)
      CODE_NRZ:  secondLvl = bitReg;
      CODE_NRZI: secondLvl = prevLvl;
      CODE_RZ:   secondLvl = 1'b0;
      default:   secondLvl = ~bitReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lineOut <= 1'b0;
      prevLvl <= 1'b0;
      bitReg  <= 1'b0;
      modeReg <= CODE_NRZ;
    end else if (strobe.loadBit) begin
      bitReg  <= dataIn;
      modeReg <= modeIn;
      lineOut <= firstLvl;
      if (modeIn == CODE_NRZI) prevLvl <= firstLvl;
    end else if (strobe.secondHalf) begin
      lineOut <= secondLvl;
    end
  end
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dataIn,
  input  logic [MODE_W-1:0] modeSel,
  output logic              lineOut
);
  encStrobe_t strobe;
  logic       phase;
  lineCode_e  modeReg;

  line_enc_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .strobe (strobe)
  );

  line_enc_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .modeSel (modeSel),
    .modeReg (modeReg),
    .lineOut (lineOut)
  );
endmodule

// File: rtl/line_encoder_checker.sv
module line_encoder_checker
  import line_enc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      phase,
  input lineCode_e modeReg,
  input logic      lineOut
);
  AST_RESET_LOW: assert property (@(posedge clk) rst |=> (!lineOut && !phase)); // R1

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    phase |=> !phase); // R2

  AST_MODE_HELD_MIDBIT: assert property (@(posedge clk) disable iff (rst)
    phase |=> $stable(modeReg)); // R8

  AST_LEVEL_FLAT_NRZ: assert property (@(posedge clk) disable iff (rst)
    (phase && (modeReg == CODE_NRZ || modeReg == CODE_NRZI)) |=> $stable(lineOut)); // R3

  AST_RZ_RETURNS_LOW: assert property (@(posedge clk) disable iff (rst)
    (phase && modeReg == CODE_RZ) |=> !lineOut); // R6

  AST_MAN_MIDBIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (phase && modeReg == CODE_MAN) |=> (lineOut != $past(lineOut))); // R7
endmodule

bind line_encoder line_encoder_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase   (phase),
  .modeReg (modeReg),
  .lineOut (lineOut)
);

// File: tb/line_encoder_test.sv
module line_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dataIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       lineOut;

  int  nTests = 0;
  int  nFail  = 0;
  logic refPrev = 1'b0;

  line_encoder uut (
    .clk     (clk),
    .rst     (rst),
    .dataIn  (dataIn),
    .modeSel (modeSel),
    .lineOut (lineOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: lineOut=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m, input logic d);
    case (m)
      2'b00:   return "R3 nrz";
      2'b01:   return d ? "R5 nrzi one" : "R4 nrzi zero";
      2'b10:   return "R6 rz";
      default: return "R7 manchester";
    endcase
  endfunction

  // Called in clock-low phase; returns in clock-low phase after the bit.
  task automatic sendBit(input logic d, input logic [1:0] m, input bit garble);
    logic expFirst;
    logic expSecond;
    dataIn  = d;
    modeSel = m;
    case (m)
      2'b01:   expFirst = refPrev ^ d;
      default: expFirst = d;
    endcase
    if (m == 2'b01) refPrev = expFirst;
    case (m)
      2'b00:   expSecond = d;
      2'b01:   expSecond = refPrev;
      2'b10:   expSecond = 1'b0;
      default: expSecond = ~d;
    endcase
    @(posedge clk);
    #1;
    if (garble) begin
      dataIn  = ~d;
      modeSel = m + 2'd1;
    end
    @(negedge clk);
    check({modeTag(m, d), " first half"}, lineOut, expFirst);
    @(posedge clk);
    @(negedge clk);
    check(garble ? {"R8 ", modeTag(m, d), " second half"}
                 : {modeTag(m, d), " second half"}, lineOut, expSecond);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, lineOut=%0b expected=done", lineOut);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset level", lineOut, 1'b0);
    rst = 1'b0;
    refPrev = 1'b0;

    // R2: output does not follow inputs between edges
    dataIn = 1'b1;
    modeSel = 2'b00;
    #1;
    check("R2 no combinational path", lineOut, 1'b0);
    sendBit(1'b1, 2'b00, 1'b0);

    // Exhaustive 4-bit sequences in every mode
    for (int m = 0; m < 4; m++) begin
      for (int pat = 0; pat < 16; pat++) begin
        for (int b = 0; b < 4; b++) begin
          sendBit(pat[b], m[1:0], 1'b0);
        end
      end
    end

    // R8: mid-bit input changes in every mode and bit value
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        sendBit(d[0], m[1:0], 1'b1);
      end
    end

    // R9: reference survives other modes
    sendBit(1'b1, 2'b01, 1'b0);
    begin
      logic saved;
      saved = refPrev;
      sendBit(1'b1, 2'b11, 1'b0);
      sendBit(1'b0, 2'b10, 1'b0);
      sendBit(1'b1, 2'b00, 1'b0);
      sendBit(1'b0, 2'b00, 1'b0);
      dataIn = 1'b0;
      modeSel = 2'b01;
      @(posedge clk);
      @(negedge clk);
      check("R9 nrzi resumes from last nrzi level", lineOut, saved);
      @(posedge clk);
      @(negedge clk);
    end

    // Mixed-mode pseudo-random run
    for (int i = 0; i < 400; i++) begin
      sendBit(1'(($urandom >> 3) & 1), 2'(($urandom >> 5) & 3), 1'(i % 3 == 0));
    end

    // R1: reset in the middle of a run clears the reference
    sendBit(1'b1, 2'b01, 1'b0);
    if (refPrev == 1'b0) sendBit(1'b1, 2'b01, 1'b0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 reset mid-run", lineOut, 1'b0);
    rst = 1'b0;
    refPrev = 1'b0;
    dataIn = 1'b1;
    modeSel = 2'b01;
    @(posedge clk);
    @(negedge clk);
    check("R1 nrzi reference cleared", lineOut, 1'b1);
    @(posedge clk);
    @(negedge clk);
    refPrev = 1'b1;
    sendBit(1'b0, 2'b01, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule